// File: doc/BRIEF.md
# Dadda Column-Compression Multiplier, 4x4 Unsigned

This block multiplies two unsigned 4-bit operands and returns the full 8-bit product. An array of AND gates forms all sixteen partial-product bits in parallel. A column-compression tree then brings the tallest column down to two bits. It does this with the least possible number of counter stages, and it places each counter as late as it can. A ripple carry-propagate adder turns the two remaining carry-save rows into a binary number.

The schedule is fixed and written out counter by counter. The first stage lowers the maximum column height from four to three using two half adders. The second stage lowers it from three to two using four full adders. Because compression is deferred, the final adder spans six bit positions. A parameter selects whether the product comes straight from the adder or passes through one output register stage.

Top module: `dadda_mul4`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `mul_a * mul_b` as an 8-bit value, with no bit dropped.
- R2: Partial-product bit (i, j) is `mul_b[i] & mul_a[j]` and carries weight 2^(i+j), so a one-hot `mul_a` at bit j and a one-hot `mul_b` at bit i give a product of exactly 2^(i+j).
- R3: The tree works in two stages. The first stage uses half adders at weights 3 and 4 only, bringing the height from 4 down to 3. The second stage uses full adders at weights 2, 3, 4 and 5 only, bringing the height from 3 down to 2. The sum of the two output rows always equals the sum of the weighted partial products.
- R4: Product bit 0 comes directly from `mul_a[0] & mul_b[0]`. A 6-bit carry-propagate adder covers weights 1 to 6, and its carry out drives product bit 7.
- R5: With `OUT_REG` = 1, `product` takes the product of the operands present at a rising clock edge and holds that value until the next rising edge.
- R6: With `OUT_REG` = 1, driving `rst_n` low clears `product` to 0 at once, without waiting for a clock edge. It stays 0 while `rst_n` is low, whatever the operands are.
- R7: With `OUT_REG` = 0, `product` follows operand changes without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| mul_a | input | 4 | Unsigned multiplicand |
| mul_b | input | 4 | Unsigned multiplier |
| product | output | 8 | Unsigned product |

## Verification
The hardest case to reach from the ports is a carry that leaves the second-stage full adder at weight 5. It lands in weight 6 and then has to ripple through the last adder position into product bit 7. This happens only when both operands are large. The stimulus therefore sweeps all 256 operand pairs, adds directed all-ones and one-hot pairs, and adds seeded random pairs. Register hold and asynchronous clear are checked by changing the operands and reset between clock edges.

// File: rtl/dadda_pkg.sv
package dadda_pkg;
  localparam int unsigned OPW   = 4;
  localparam int unsigned PW    = 2 * OPW;
  localparam int unsigned NPP   = OPW * OPW;
  localparam int unsigned CPA_W = PW - 2;

  typedef logic [OPW-1:0] opnd_t;
  typedef logic [PW-1:0]  prod_t;
  typedef logic [NPP-1:0] pp_t;

  // Two carry-save rows; the second row has no bit at weight 0.
  typedef struct packed {
    logic [PW-2:0] row_a;
    logic [PW-2:1] row_b;
  } csa_rows_t;

  function automatic prod_t pp_weighted_sum(pp_t pp);
    prod_t acc;
    acc = '0;
    for (int i = 0; i < OPW; i++)
      for (int j = 0; j < OPW; j++)
        acc = acc + (prod_t'(pp[i*OPW+j]) << (i + j));
    return acc;
  endfunction
endpackage

// File: rtl/dadda_cells.sv
module dadda_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

module dadda_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dadda_ppgen.sv
module dadda_ppgen
  import dadda_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  opnd_t mul_a,
  input  opnd_t mul_b,
  output pp_t   pp
);
  for (genvar gi = 0; gi < OPW; gi++) begin : g_row
    for (genvar gj = 0; gj < OPW; gj++) begin : g_col
      assign pp[gi*OPW+gj] = mul_b[gi] & mul_a[gj];
    end
  end

  // R2: AND array yields popcount(a) * popcount(b) set bits
  p_pp_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pp) == $countones(mul_a) * $countones(mul_b));
endmodule

// File: rtl/dadda_tree.sv
module dadda_tree
  import dadda_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pp_t       pp,
  output csa_rows_t rows
);
  logic p [OPW][OPW];
  for (genvar gi = 0; gi < OPW; gi++) begin : g_pi
    for (genvar gj = 0; gj < OPW; gj++) begin : g_pj
      assign p[gi][gj] = pp[gi*OPW+gj];
    end
  end

  // Stage 1: height limit 3, half adders at weights 3 and 4
  logic s1_w3, c1_w4, s1_w4, c1_w5;
  dadda_ha u_ha_w3 (.x(p[0][3]), .y(p[1][2]), .s(s1_w3), .c(c1_w4));
  dadda_ha u_ha_w4 (.x(p[1][3]), .y(p[2][2]), .s(s1_w4), .c(c1_w5));

  // Stage 2: height limit 2, full adders at weights 2..5
  logic s2_w2, c2_w3, s2_w3, c2_w4, s2_w4, c2_w5, s2_w5, c2_w6;
  dadda_fa u_fa_w2 (.x(p[0][2]), .y(p[1][1]), .z(p[2][0]), .s(s2_w2), .c(c2_w3));
  dadda_fa u_fa_w3 (.x(s1_w3),   .y(p[2][1]), .z(p[3][0]), .s(s2_w3), .c(c2_w4));
  dadda_fa u_fa_w4 (.x(s1_w4),   .y(p[3][1]), .z(c1_w4),   .s(s2_w4), .c(c2_w5));
  dadda_fa u_fa_w5 (.x(p[2][3]), .y(p[3][2]), .z(c1_w5),   .s(s2_w5), .c(c2_w6));

  assign rows.row_a = {p[3][3], s2_w5, s2_w4, s2_w3, s2_w2, p[0][1], p[0][0]};
  assign rows.row_b = {c2_w6, c2_w5, c2_w4, c2_w3, 1'b0, p[1][0]};

  // R3: compression preserves the weighted column sum
  p_tree_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prod_t'(rows.row_a) + prod_t'({rows.row_b, 1'b0}) == pp_weighted_sum(pp));
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;
  always_comb begin
    cy[0] = 1'b0;
    for (int k = 0; k < W; k++) begin
      sum[k]  = x[k] ^ y[k] ^ cy[k];
      cy[k+1] = (x[k] & y[k]) | (cy[k] & (x[k] ^ y[k]));
    end
  end
  assign cout = cy[W];
endmodule

// File: rtl/dadda_mul4.sv
module dadda_mul4
  import dadda_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mul_a,
  input  logic [3:0] mul_b,
  output logic [7:0] product
);
  pp_t             pp;
  csa_rows_t       rows;
  logic [CPA_W-1:0] cpa_sum;
  logic            cpa_cout;
  prod_t           prod_comb;

  dadda_ppgen u_ppgen (.clk(clk), .rst_n(rst_n), .mul_a(mul_a), .mul_b(mul_b), .pp(pp));
  dadda_tree  u_tree  (.clk(clk), .rst_n(rst_n), .pp(pp), .rows(rows));
  dadda_cpa #(.W(CPA_W)) u_cpa (
    .x(rows.row_a[PW-2:1]), .y(rows.row_b), .sum(cpa_sum), .cout(cpa_cout));

  assign prod_comb = {cpa_cout, cpa_sum, rows.row_a[0]};

  // R4: weight 0 bypasses the adder
  p_lsb_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prod_comb[0] == (mul_a[0] & mul_b[0]));

  if (OUT_REG) begin : g_reg
    prod_t prod_d, prod_q;
    always_comb prod_d = prod_comb;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_d;
    end
    assign product = prod_q;

    // R5: registered product lags operands by one edge
    p_reg_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> product == $past(PW'(mul_a) * PW'(mul_b)));
  end else begin : g_comb
    assign product = prod_comb;

    // R1: combinational product is exact
    p_comb_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
      product == PW'(mul_a) * PW'(mul_b));
  end
endmodule

// File: tb/test_dadda_mul4.sv
module test_dadda_mul4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mul_a = 4'd9;
  logic [3:0] mul_b = 4'd7;
  logic [7:0] prod_reg, prod_cmb;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dadda_mul4 #(.OUT_REG(1'b1)) i_dadda_mul4 (
    .clk(clk), .rst_n(rst_n), .mul_a(mul_a), .mul_b(mul_b), .product(prod_reg));
  dadda_mul4 #(.OUT_REG(1'b0)) i_dadda_mul4_comb (
    .clk(clk), .rst_n(rst_n), .mul_a(mul_a), .mul_b(mul_b), .product(prod_cmb));

  function automatic logic [7:0] ref_mul(logic [3:0] x, logic [3:0] y);
    int unsigned r;
    r = int'(x) * int'(y);
    return r[7:0];
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d got %0d expected %0d", req, mul_a, mul_b, got, exp);
    end
  endtask

  // Drive between edges, check comb output, then registered output after the edge
  task automatic apply(logic [3:0] x, logic [3:0] y, string req);
    @(negedge clk);
    mul_a = x;
    mul_b = y;
    #1 check(req, prod_cmb, ref_mul(x, y));
    @(posedge clk);
    #1 check("R5", prod_reg, ref_mul(x, y));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // R6: reset state with clock running
    repeat (3) @(posedge clk);
    #1 check("R6", prod_reg, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    // R2: one-hot operands land at weight i+j
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        apply(4'(1 << j), 4'(1 << i), "R2");

    // R3/R4 corners: all ones fills every column, carry into bit 7
    apply(4'hF, 4'hF, "R3");
    apply(4'hF, 4'hE, "R4");
    apply(4'hD, 4'hB, "R4");
    apply(4'h0, 4'hF, "R1");
    apply(4'hF, 4'h0, "R1");

    // R5 hold and R7 follow: change operands mid-cycle
    apply(4'd12, 4'd11, "R1");
    #2 mul_a = 4'd3; mul_b = 4'd5;
    #2 check("R7", prod_cmb, 8'd15);
    check("R5", prod_reg, 8'd132);

    // R6: asynchronous clear between edges, holds while low
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 check("R6", prod_reg, 8'd0);
    mul_a = 4'd14; mul_b = 4'd13;
    @(posedge clk);
    #1 check("R6", prod_reg, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: exhaustive sweep of all operand pairs
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        apply(4'(x), 4'(y), "R1");

    // R1: seeded random pairs
    for (int k = 0; k < 200; k++)
      apply(4'($urandom), 4'($urandom), "R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule